// File: doc/BRIEF.md
# Serial Time-Load Write Port

This block is the write side of a real-time clock's three-wire serial port. A host opens a write by raising the enable line `en_i` while the write select `wsel_i` is high. It then clocks in one fixed 52-bit frame of time data on `sdi_i`, one bit per rising edge of `sck_i`, least significant bit first. The block runs on a fast system clock. It brings all four serial lines into that domain through a synchronizer and detects their edges there. Every control output is therefore a clean registered level or a single-cycle pulse.

While a frame is arriving, the block holds off the external seconds counter and keeps the sub-second divider stages (1 Hz to 128 Hz) in reset during the first bit period. When the 52nd bit has arrived, it presents the whole frame in parallel and strobes a load into the external timekeeping counters. The frame is all or nothing. If the write ends early, the partial frame is dropped and an abort pulse is raised. Bits clocked in after the 52nd are ignored.

The control is a three-state machine:
- `ST_IDLE` covers no write and a frame register held at zero. It goes to `ST_SHIFT` when enable and write select are both seen high.
- `ST_SHIFT` collects bits. It goes to `ST_FULL` on the 52nd rising serial clock. It returns to `ST_IDLE` with an abort pulse if the write becomes inactive.
- `ST_FULL` holds the complete frame and ignores further bits. It goes to `ST_IDLE` when the write becomes inactive.

Top module: `rtc_wr_port`

## Requirements
- R1: While `rst_n` is low, all outputs are zero: `sec_stop_o`, `div_rst_o`, `load_o`, `abort_o`, and every bit of `frame_o`.
- R2: Bits are accepted only while `en_i` and `wsel_i` are both high. Serial clock activity with `wsel_i` low and `en_i` high shifts no bit, gives no load or abort, and leaves `frame_o` at zero.
- R3: A bit is taken on each rising edge of `sck_i`. Each new bit enters `frame_o[51]`, and the bits already held move one place toward bit 0. After a full frame, the first bit received (the seconds-field weight-1 bit) is at `frame_o[0]`, and the last bit (year-field weight 80) is at `frame_o[51]`.
- R4: `load_o` is high for exactly one system clock. This happens when the 52nd bit of a write is taken, and `frame_o` holds the complete frame in that cycle.
- R5: Serial clock edges after the 52nd bit of the same write leave `frame_o` unchanged and give no further `load_o`.
- R6: If the write becomes inactive (either `en_i` or `wsel_i` low) before 52 bits, `load_o` is not raised and `abort_o` pulses for one cycle. `frame_o` returns to zero in that same cycle.
- R7: `sec_stop_o` rises on the first falling edge of `sck_i` within a write. It stays high through the rest of the frame and after `en_i` falls. It is cleared by the next rising edge of `en_i`.
- R8: `div_rst_o` is high from the first rising edge of `sck_i` in a write until the second rising edge, and low at all other times.
- R9: Each port change takes effect on the third rising edge of `clk` after it. This is two synchronizer stages plus one edge-history register, and all outputs are registered.
- R10: Once a write ends, `frame_o` returns to zero. It stays at zero until bits of a new write arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Serial port enable from the host |
| wsel_i | input | 1 | Write select, high for a write transaction |
| sck_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data, least significant bit first |
| sec_stop_o | output | 1 | Blocks the seconds increment of the external counter |
| div_rst_o | output | 1 | Holds the 1 Hz to 128 Hz divider stages in reset |
| load_o | output | 1 | One-cycle strobe to load `frame_o` into the timekeeping counters |
| abort_o | output | 1 | One-cycle pulse when a short frame is discarded |
| frame_o | output | 52 | Parallel frame, valid while `load_o` is high |

## Verification
Every serial-side event becomes visible on the outputs after the third `clk` edge that follows the port change. That latency is one edge for each of the two synchronizer stages and one for the edge-history register, and the output registers update on that same edge. The bench changes inputs 3 ns after a rising edge and feeds its reference model the input history delayed by two and three samples. It compares every output at each falling edge, so each result is checked in exactly the cycle it is due. Directed checks wait for the same falling edge after the third rising edge before reading the frame, the strobe counts, the divider reset and the freeze level.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } wr_state_e;

    // Channel positions inside the synchronized input bundle
    localparam int CH_EN  = 0;
    localparam int CH_WS  = 1;
    localparam int CH_SCK = 2;
    localparam int CH_SDI = 3;
    localparam int N_CH   = 4;

endpackage

// File: rtl/rtcw_sync_edge.sv
module rtcw_sync_edge #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] pipe [STAGES];
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pipe[STAGES-1];
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev_q;
    assign fall = ~pipe[STAGES-1] & prev_q;

endmodule

// File: rtl/rtcw_shreg.sv
module rtcw_shreg #(
    parameter int W  = 52,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift,
    input  logic          din,
    output logic [W-1:0]  data,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            data <= '0;
            cnt  <= '0;
        end else if (shift && (cnt < CW'(W))) begin
            data <= {din, data[W-1:1]};
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_wr_port.sv
module rtc_wr_port #(
    parameter int FRAME_BITS  = 52,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  wsel_i,
    input  logic                  sck_i,
    input  logic                  sdi_i,
    output logic                  sec_stop_o,
    output logic                  div_rst_o,
    output logic                  load_o,
    output logic                  abort_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    import rtcw_pkg::*;

    localparam int CW = $clog2(FRAME_BITS + 1);

    logic [N_CH-1:0] lvl, rise, fall;
    logic [N_CH-1:0] raw_in;

    assign raw_in[CH_EN]  = en_i;
    assign raw_in[CH_WS]  = wsel_i;
    assign raw_in[CH_SCK] = sck_i;
    assign raw_in[CH_SDI] = sdi_i;

    rtcw_sync_edge #(
        .N      (N_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    wr_state_e       state_q, state_d;
    logic            active;
    logic            sck_up, sck_dn, en_up;
    logic            shift_en, clr_frame, last_bit;
    logic [CW-1:0]   bit_cnt;

    assign active = lvl[CH_EN] & lvl[CH_WS];
    assign sck_up = rise[CH_SCK];
    assign sck_dn = fall[CH_SCK];
    assign en_up  = rise[CH_EN];

    assign shift_en  = (state_q == ST_SHIFT) && active && sck_up;
    assign clr_frame = (state_q == ST_IDLE) || !active;
    assign last_bit  = shift_en && (bit_cnt == CW'(FRAME_BITS - 1));

    rtcw_shreg #(
        .W  (FRAME_BITS),
        .CW (CW)
    ) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_frame),
        .shift (shift_en),
        .din   (lvl[CH_SDI]),
        .data  (frame_o),
        .cnt   (bit_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active)        state_d = ST_SHIFT;
            ST_SHIFT: if (!active)       state_d = ST_IDLE;
                      else if (last_bit) state_d = ST_FULL;
            ST_FULL:  if (!active)       state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_stop_o <= 1'b0;
            div_rst_o  <= 1'b0;
            load_o     <= 1'b0;
            abort_o    <= 1'b0;
        end else begin
            load_o  <= last_bit;
            abort_o <= (state_q == ST_SHIFT) && !active;

            if ((state_q != ST_IDLE) && active && sck_dn)
                sec_stop_o <= 1'b1;
            else if (en_up)
                sec_stop_o <= 1'b0;

            if ((state_q != ST_SHIFT) || !active)
                div_rst_o <= 1'b0;
            else if (shift_en && (bit_cnt == '0))
                div_rst_o <= 1'b1;
            else if (shift_en && (bit_cnt == CW'(1)))
                div_rst_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rtcw_chk.sv
module rtcw_chk
    import rtcw_pkg::*;
#(
    parameter int W  = 52,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_stop_o,
    input  logic          div_rst_o,
    input  logic          load_o,
    input  logic          abort_o,
    input  logic [W-1:0]  frame_o,
    input  wr_state_e     state,
    input  logic [CW-1:0] cnt
);

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R4

    AST_LOAD_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (cnt == CW'(W) && state == ST_FULL)); // R4

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && $past(state == ST_FULL)) |-> $stable(frame_o)); // R5

    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (frame_o == '0 && cnt == '0 && !load_o)); // R6

    AST_FREEZE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> sec_stop_o); // R7

    AST_DIV_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_o |-> (cnt == CW'(1) && state == ST_SHIFT)); // R8

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (frame_o == '0 && cnt == '0)); // R10

endmodule

bind rtc_wr_port rtcw_chk #(
    .W  (FRAME_BITS),
    .CW (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_stop_o (sec_stop_o),
    .div_rst_o  (div_rst_o),
    .load_o     (load_o),
    .abort_o    (abort_o),
    .frame_o    (frame_o),
    .state      (state_q),
    .cnt        (bit_cnt)
);

// File: tb/tb_rtc_wr_port.sv
module tb_rtc_wr_port;
    localparam int W = 52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, wsel_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0;
    logic sec_stop_o, div_rst_o, load_o, abort_o;
    logic [W-1:0] frame_o;

    always #5 clk = ~clk;

    rtc_wr_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .wsel_i     (wsel_i),
        .sck_i      (sck_i),
        .sdi_i      (sdi_i),
        .sec_stop_o (sec_stop_o),
        .div_rst_o  (div_rst_o),
        .load_o     (load_o),
        .abort_o    (abort_o),
        .frame_o    (frame_o)
    );

    int n_chk = 0, n_err = 0, n_load = 0, n_abort = 0;
    bit done = 1'b0;

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: input history queue, integer state,
    // received bits kept as a queue.
    logic [3:0] hist[$];   // {sdi, sck, wsel, en}; [0] newest
    bit         m_bits[$];
    int         m_st;      // 0 idle, 1 collecting, 2 complete
    logic       e_frz, e_div, e_load, e_abort;

    function automatic logic [W-1:0] m_frame();
        logic [W-1:0] f = '0;
        for (int i = 0; i < m_bits.size(); i++) f[W - m_bits.size() + i] = m_bits[i];
        return f;
    endfunction

    task automatic model_reset();
        hist = '{4'b0, 4'b0, 4'b0};
        m_bits.delete();
        m_st = 0;
        e_frz = 0; e_div = 0; e_load = 0; e_abort = 0;
    endtask

    task automatic model_step(logic [3:0] now_in);
        logic [3:0] cur, prv;
        logic act, s_up, s_dn, en_up;
        cur = hist[1];
        prv = hist[2];
        act   = cur[0] & cur[1];
        s_up  = cur[2] & !prv[2];
        s_dn  = !cur[2] & prv[2];
        en_up = cur[0] & !prv[0];
        e_load = 0; e_abort = 0;
        if (m_st != 0 && act && s_dn) e_frz = 1;
        else if (en_up)              e_frz = 0;
        case (m_st)
            0: begin
                m_bits.delete(); e_div = 0;
                if (act) m_st = 1;
            end
            1: begin
                if (!act) begin
                    m_st = 0; e_abort = 1; m_bits.delete(); e_div = 0;
                end else if (s_up) begin
                    if (m_bits.size() == 0) e_div = 1;
                    else if (m_bits.size() == 1) e_div = 0;
                    m_bits.push_back(cur[3]);
                    if (m_bits.size() == W) begin m_st = 2; e_load = 1; end
                end
            end
            default: begin
                if (!act) begin m_st = 0; m_bits.delete(); end
            end
        endcase
        hist.push_front(now_in);
        void'(hist.pop_back());
    endtask

    initial model_reset();

    // Every-cycle comparison; the model delays inputs by the three-edge latency (R9)
    always @(negedge clk) begin
        if (!done) begin
            check("R7", "sec_stop", W'(sec_stop_o), W'(e_frz));
            check("R8", "div_rst",  W'(div_rst_o),  W'(e_div));
            check("R4", "load",     W'(load_o),     W'(e_load));
            check("R6", "abort",    W'(abort_o),    W'(e_abort));
            check("R3", "frame",    frame_o,        m_frame());
            if (load_o)  n_load++;
            if (abort_o) n_abort++;
            if (!rst_n) model_reset();
            else        model_step({sdi_i, sck_i, wsel_i, en_i});
        end
    end

    task automatic put(logic e, logic w, logic k, logic d);
        @(posedge clk); #3;
        en_i = e; wsel_i = w; sck_i = k; sdi_i = d;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(logic w, logic b);
        put(1'b1, w, 1'b0, b); wait_clk(3);
        put(1'b1, w, 1'b1, b); wait_clk(3);
    endtask

    task automatic dcheck(string req, string what, logic [W-1:0] act_now_unused, logic [W-1:0] exp);
        // value is re-read after the next falling edge
        @(negedge clk);
        case (what)
            "frame":    check(req, what, frame_o, exp);
            "sec_stop": check(req, what, W'(sec_stop_o), exp);
            "div_rst":  check(req, what, W'(div_rst_o), exp);
            "loads":    check(req, what, W'(n_load), exp);
            "aborts":   check(req, what, W'(n_abort), exp);
            default:    check(req, what, W'(load_o | abort_o), exp);
        endcase
        if (act_now_unused === 'x) ;
    endtask

    function automatic bit pat_a(int i);
        return ((i * 5 + 1) % 3) == 0;
    endfunction

    function automatic bit pat_b(int i);
        return ((i & 1) ^ ((i >> 3) & 1)) != 0;
    endfunction

    initial begin
        logic [W-1:0] exp_a, exp_b;
        for (int i = 0; i < W; i++) begin
            exp_a[i] = pat_a(i);
            exp_b[i] = pat_b(i);
        end

        wait_clk(2);
        dcheck("R1", "frame",    '0, '0);
        dcheck("R1", "sec_stop", '0, '0);
        dcheck("R1", "div_rst",  '0, '0);
        dcheck("R1", "strobes",  '0, '0);
        @(posedge clk); #3 rst_n = 1'b1;
        wait_clk(5);

        // Frame A with three extra bits
        put(1, 1, 0, 0); wait_clk(4);
        for (int i = 0; i < W; i++) send_bit(1'b1, pat_a(i));
        dcheck("R3", "frame", '0, exp_a);
        dcheck("R4", "loads", '0, W'(1));
        for (int i = 0; i < 3; i++) send_bit(1'b1, !pat_a(i));
        wait_clk(4);
        dcheck("R5", "frame", '0, exp_a);
        dcheck("R5", "loads", '0, W'(1));
        put(0, 0, 0, 0); wait_clk(6);
        dcheck("R10", "frame", '0, '0);
        dcheck("R7", "sec_stop", '0, W'(1));
        put(1, 0, 0, 0); wait_clk(5);
        dcheck("R7", "sec_stop", '0, '0);
        put(0, 0, 0, 0); wait_clk(6);

        // Short frame of 10 bits
        put(1, 1, 0, 0); wait_clk(4);
        for (int i = 0; i < 10; i++) send_bit(1'b1, pat_b(i));
        put(0, 0, 0, 0); wait_clk(6);
        dcheck("R6", "aborts", '0, W'(1));
        dcheck("R6", "loads",  '0, W'(1));
        dcheck("R6", "frame",  '0, '0);
        put(1, 0, 0, 0); wait_clk(5);
        put(0, 0, 0, 0); wait_clk(6);

        // Enable high, write select low: nothing taken
        put(1, 0, 0, 0); wait_clk(4);
        for (int i = 0; i < 20; i++) send_bit(1'b0, pat_a(i));
        wait_clk(4);
        dcheck("R2", "frame",    '0, '0);
        dcheck("R2", "sec_stop", '0, '0);
        dcheck("R2", "loads",    '0, W'(1));
        dcheck("R2", "aborts",   '0, W'(1));
        put(0, 0, 0, 0); wait_clk(6);

        // Frame B, exactly 52 bits, divider reset window probed
        put(1, 1, 0, 0); wait_clk(4);
        send_bit(1'b1, pat_b(0));
        dcheck("R8", "div_rst", '0, W'(1));
        send_bit(1'b1, pat_b(1));
        dcheck("R8", "div_rst", '0, '0);
        for (int i = 2; i < W; i++) send_bit(1'b1, pat_b(i));
        wait_clk(2);
        dcheck("R3", "frame", '0, exp_b);
        dcheck("R4", "loads", '0, W'(2));
        put(0, 0, 0, 0); wait_clk(6);
        dcheck("R10", "frame", '0, '0);

        // Write select drops mid-frame
        put(1, 1, 0, 0); wait_clk(4);
        for (int i = 0; i < 5; i++) send_bit(1'b1, pat_a(i));
        put(1, 0, 0, 0); wait_clk(6);
        dcheck("R6", "aborts", '0, W'(2));
        dcheck("R6", "frame",  '0, '0);
        put(0, 0, 0, 0); wait_clk(6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule